// File: doc/BRIEF.md
# Register-Pair Doubleword Instruction Expander

This block sits in the fetch/decode path of a 32-bit core that supports 64-bit loads and stores into even/odd register pairs. It takes one instruction word per cycle. When the low two bits mark a 16-bit compressed instruction, it recognises the four pair forms: load relative to the stack pointer, store relative to the stack pointer, load from a base register and store from a base register. It rewrites each of them into the equivalent full-width doubleword load or store. Compressed offsets are zero-extended and scaled by 8. The stack-pointer forms use x2 as the base. The 3-bit register fields of the base-register forms select x8 to x15.

A mode input tells the expander that the compressed single-precision float encodings are in use. Those encodings share code points with the pair forms, so while the mode is set the compressed pair forms are not recognised. Full-width doubleword loads and stores are passed through unchanged, whatever the mode. On both paths, a data register with an odd number is flagged as reserved, and a compressed stack-pointer load into x0 is also flagged as reserved. Reserved words are flagged and never expanded. Any other instruction gives a low valid flag.

The result is registered. It appears on the outputs one clock after the input is sampled.

Top module: `zpx_pair_expander`

## Requirements
- R1: While `rst_n` is low, `out_vld`, `out_illegal` and `out_word` are all zero, whatever the inputs are.
- R2: The outputs show the result for the input sampled at the previous rising clock edge. When `in_vld` was low at that edge, all three outputs are zero.
- R3: A compressed word with bits[1:0]=10 and bits[15:13]=011 is a stack-pointer load. rd is in bits 11:7, offset[5] is in bit 12, offset[4:3] is in bits 6:5 and offset[8:6] is in bits 4:2. If rd is even and nonzero, the output is `ld rd, off(x2)` with valid=1 and illegal=0. The load word is opcode 0000011 in bits 6:0, rd in bits 11:7, funct3=011 in bits 14:12, rs1 in bits 19:15, and the zero-extended offset in bits 31:20.
- R4: A stack-pointer load whose rd is x0 or odd gives valid=1, illegal=1 and word=0.
- R5: A compressed word with bits[1:0]=10 and bits[15:13]=111 is a stack-pointer store. rs2 is in bits 6:2, offset[5:3] is in bits 12:10 and offset[8:6] is in bits 9:7. If rs2 is even, including x0, the output is `sd rs2, off(x2)`. The store word is opcode 0100011, offset[4:0] in bits 11:7, funct3=011, rs1 in bits 19:15, rs2 in bits 24:20 and offset[11:5] in bits 31:25.
- R6: A stack-pointer store with an odd rs2 gives valid=1, illegal=1 and word=0.
- R7: A compressed word with bits[1:0]=00 and bits[15:13]=011 is a base-register load. The register field in bits 4:2 names the destination and the field in bits 9:7 names the base, each as x(8+field). offset[7:6] is in bits 6:5 and offset[5:3] is in bits 12:10. The output is the expanded `ld`.
- R8: A compressed word with bits[1:0]=00 and bits[15:13]=111 is a base-register store. Its fields sit in the same places as in R7, with bits 4:2 naming rs2. The output is the expanded `sd`.
- R9: A base-register load or store whose data field has bit 2 of the word set (an odd register) gives valid=1, illegal=1 and word=0.
- R10: While `fp_cmode` is high, none of the four compressed pair forms is recognised and valid stays low.
- R11: Any other compressed word gives valid=0, illegal=0 and word=0.
- R12: A full-width word with opcode 0000011 or 0100011 and funct3=011, whose data register (bits 11:7 for a load, bits 24:20 for a store) is even, is passed through unchanged with valid=1. This holds whatever the value of `fp_cmode`.
- R13: A full-width pair word with an odd data register gives valid=1, illegal=1 and word=0. Any other full-width word gives valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input word is present |
| in_word | input | 32 | Instruction word; only bits 15:0 are used for compressed words |
| fp_cmode | input | 1 | High when the compressed float encodings are in use instead of the pair forms |
| out_vld | output | 1 | A pair load/store was recognised |
| out_word | output | 32 | Expanded or passed-through word; zero when illegal or not valid |
| out_illegal | output | 1 | The recognised word uses a reserved register choice |

## Verification
Two functions can act in the same cycle: the float-mode suppression and the full-width bypass. In that case the mode is high while a 32-bit pair word arrives. The bench replays bypass vectors with `fp_cmode` set and expects them to pass unchanged, while compressed pair words under the same mode must give valid low. The reserved-register flag and the valid flag also rise together. For each reserved case, the bench checks that valid and illegal are both high and that the word is zero.

// File: rtl/zpx_pkg.sv
package zpx_pkg;
    localparam int ILEN   = 32;
    localparam int REG_W  = 5;
    localparam int OFF_W  = 9;
    localparam int IMM_W  = 12;
    localparam int CREG_W = 3;
    localparam logic [6:0] OP_LOAD  = 7'b0000011;
    localparam logic [6:0] OP_STORE = 7'b0100011;
    localparam logic [2:0] F3_DBL   = 3'b011;
    localparam logic [REG_W-1:0] SP_REG = 5'd2;

    typedef enum logic [2:0] {
        FORM_NONE,
        FORM_SP_LD,
        FORM_SP_SD,
        FORM_RG_LD,
        FORM_RG_SD,
        FORM_W_LD,
        FORM_W_SD
    } form_e;

    typedef struct packed {
        logic            vld;
        logic            ill;
        logic [ILEN-1:0] word;
    } exp_t;

    function automatic logic [ILEN-1:0] mk_load(input logic [REG_W-1:0] rd,
                                                input logic [REG_W-1:0] rs1,
                                                input logic [OFF_W-1:0] off);
        logic [IMM_W-1:0] imm;
        imm = {{(IMM_W-OFF_W){1'b0}}, off};
        return {imm, rs1, F3_DBL, rd, OP_LOAD};
    endfunction

    function automatic logic [ILEN-1:0] mk_store(input logic [REG_W-1:0] rs2,
                                                 input logic [REG_W-1:0] rs1,
                                                 input logic [OFF_W-1:0] off);
        logic [IMM_W-1:0] imm;
        imm = {{(IMM_W-OFF_W){1'b0}}, off};
        return {imm[11:5], rs2, rs1, F3_DBL, imm[4:0], OP_STORE};
    endfunction
endpackage

// File: rtl/zpx_form_decode.sv
module zpx_form_decode
    import zpx_pkg::*;
(
    input  logic [1:0] quad,
    input  logic [2:0] cf3,
    input  logic [6:0] wop,
    input  logic [2:0] wf3,
    input  logic       fp_cmode,
    output form_e      form
);
    always_comb begin
        form = FORM_NONE;
        if (quad == 2'b11) begin
            if (wop == OP_LOAD && wf3 == F3_DBL) begin
                form = FORM_W_LD;
            end else if (wop == OP_STORE && wf3 == F3_DBL) begin
                form = FORM_W_SD;
            end
        end else if (!fp_cmode) begin
            unique case ({quad, cf3})
                5'b10_011: form = FORM_SP_LD;
                5'b10_111: form = FORM_SP_SD;
                5'b00_011: form = FORM_RG_LD;
                5'b00_111: form = FORM_RG_SD;
                default:   form = FORM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/zpx_cform_build.sv
module zpx_cform_build
    import zpx_pkg::*;
(
    input  logic [12:2] cbits,
    input  form_e       form,
    output exp_t        res
);
    logic [REG_W-1:0] sp_rd, sp_rs2, rg_dat, rg_base;
    logic [OFF_W-1:0] off_spl, off_sps, off_rg;

    always_comb begin
        sp_rd   = cbits[11:7];
        sp_rs2  = cbits[6:2];
        rg_dat  = {2'b01, cbits[4:2]};
        rg_base = {2'b01, cbits[9:7]};
        off_spl = {cbits[4:2], cbits[12], cbits[6:5], 3'b000};
        off_sps = {cbits[9:7], cbits[12:10], 3'b000};
        off_rg  = {1'b0, cbits[6:5], cbits[12:10], 3'b000};
    end

    always_comb begin
        res = '0;
        unique case (form)
            FORM_SP_LD: begin
                res.vld  = 1'b1;
                res.ill  = (sp_rd == '0) || sp_rd[0];
                res.word = res.ill ? '0 : mk_load(sp_rd, SP_REG, off_spl);
            end
            FORM_SP_SD: begin
                res.vld  = 1'b1;
                res.ill  = sp_rs2[0];
                res.word = res.ill ? '0 : mk_store(sp_rs2, SP_REG, off_sps);
            end
            FORM_RG_LD: begin
                res.vld  = 1'b1;
                res.ill  = rg_dat[0];
                res.word = res.ill ? '0 : mk_load(rg_dat, rg_base, off_rg);
            end
            FORM_RG_SD: begin
                res.vld  = 1'b1;
                res.ill  = rg_dat[0];
                res.word = res.ill ? '0 : mk_store(rg_dat, rg_base, off_rg);
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/zpx_wide_check.sv
module zpx_wide_check
    import zpx_pkg::*;
(
    input  logic [ILEN-1:0] word,
    input  form_e           form,
    output exp_t            res
);
    always_comb begin
        res = '0;
        unique case (form)
            FORM_W_LD: begin
                res.vld  = 1'b1;
                res.ill  = word[7];
                res.word = res.ill ? '0 : word;
            end
            FORM_W_SD: begin
                res.vld  = 1'b1;
                res.ill  = word[20];
                res.word = res.ill ? '0 : word;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/zpx_pair_expander.sv
module zpx_pair_expander
    import zpx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [ILEN-1:0] in_word,
    input  logic            fp_cmode,
    output logic            out_vld,
    output logic [ILEN-1:0] out_word,
    output logic            out_illegal
);
    form_e form;
    exp_t  c_res, w_res, nxt, cur;

    zpx_form_decode u_dec (
        .quad     (in_word[1:0]),
        .cf3      (in_word[15:13]),
        .wop      (in_word[6:0]),
        .wf3      (in_word[14:12]),
        .fp_cmode (fp_cmode),
        .form     (form)
    );

    zpx_cform_build u_cbuild (
        .cbits (in_word[12:2]),
        .form  (form),
        .res   (c_res)
    );

    zpx_wide_check u_wide (
        .word (in_word),
        .form (form),
        .res  (w_res)
    );

    always_comb begin
        nxt = '0;
        if (in_vld) begin
            unique case (form)
                FORM_SP_LD, FORM_SP_SD, FORM_RG_LD, FORM_RG_SD: nxt = c_res;
                FORM_W_LD, FORM_W_SD:                           nxt = w_res;
                default:                                        nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    always_comb begin
        out_vld     = cur.vld;
        out_illegal = cur.ill;
        out_word    = cur.word;
    end
endmodule

// File: rtl/zpx_pair_expander_chk.sv
module zpx_pair_expander_chk
    import zpx_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_vld,
    input logic [ILEN-1:0] in_word,
    input logic            fp_cmode,
    input logic            out_vld,
    input logic [ILEN-1:0] out_word,
    input logic            out_illegal
);
    logic w_ld_even, w_sd_even, w_pair_odd;
    always_comb begin
        w_ld_even  = in_vld && in_word[6:0] == OP_LOAD  && in_word[14:12] == F3_DBL && !in_word[7];
        w_sd_even  = in_vld && in_word[6:0] == OP_STORE && in_word[14:12] == F3_DBL && !in_word[20];
        w_pair_odd = in_vld && in_word[14:12] == F3_DBL &&
                     ((in_word[6:0] == OP_LOAD && in_word[7]) || (in_word[6:0] == OP_STORE && in_word[20]));
    end

    a_r2_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && !out_illegal && out_word == '0));

    a_r4_reserved_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_vld && out_word == '0));

    a_r10_fp_mode_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && fp_cmode && in_word[1:0] != 2'b11) |=> !out_vld);

    a_r12_bypass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (w_ld_even || w_sd_even) |=> (out_vld && !out_illegal && out_word == $past(in_word)));

    a_r13_wide_odd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        w_pair_odd |=> (out_vld && out_illegal));

    a_r3_funct3_double: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_illegal) |-> (out_word[14:12] == F3_DBL &&
            (out_word[6:0] == OP_LOAD || out_word[6:0] == OP_STORE)));
endmodule

bind zpx_pair_expander zpx_pair_expander_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_vld      (in_vld),
    .in_word     (in_word),
    .fp_cmode    (fp_cmode),
    .out_vld     (out_vld),
    .out_word    (out_word),
    .out_illegal (out_illegal)
);

// File: tb/tb_zpx_pair_expander.sv
`timescale 1ns/1ps
module tb_zpx_pair_expander;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] in_word = '0;
    logic        fp_cmode = 1'b0;
    logic        out_vld;
    logic [31:0] out_word;
    logic        out_illegal;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    zpx_pair_expander dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
        .fp_cmode(fp_cmode), .out_vld(out_vld), .out_word(out_word),
        .out_illegal(out_illegal)
    );

    // kind: 0 sp load, 1 sp store, 2 reg load, 3 reg store, 4 raw 32-bit, 5 raw 16-bit
    typedef struct packed {
        logic [2:0]  kind;
        logic        fp;
        logic [4:0]  dreg;
        logic [4:0]  breg;
        logic [8:0]  off;
        logic        vld;
        logic        ill;
        logic [31:0] raw;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 1'b0, 5'd10, 5'd2, 9'h1F8, 1'b1, 1'b0, 32'h0, "R3 "},
        '{3'd0, 1'b0, 5'd2,  5'd2, 9'h028, 1'b1, 1'b0, 32'h0, "R3 "},
        '{3'd0, 1'b0, 5'd0,  5'd2, 9'h008, 1'b1, 1'b1, 32'h0, "R4 "},
        '{3'd0, 1'b0, 5'd5,  5'd2, 9'h010, 1'b1, 1'b1, 32'h0, "R4 "},
        '{3'd1, 1'b0, 5'd0,  5'd2, 9'h1F8, 1'b1, 1'b0, 32'h0, "R5 "},
        '{3'd1, 1'b0, 5'd20, 5'd2, 9'h048, 1'b1, 1'b0, 32'h0, "R5 "},
        '{3'd1, 1'b0, 5'd7,  5'd2, 9'h018, 1'b1, 1'b1, 32'h0, "R6 "},
        '{3'd2, 1'b0, 5'd8,  5'd15, 9'h0F8, 1'b1, 1'b0, 32'h0, "R7 "},
        '{3'd2, 1'b0, 5'd14, 5'd9, 9'h040, 1'b1, 1'b0, 32'h0, "R7 "},
        '{3'd2, 1'b0, 5'd9,  5'd10, 9'h008, 1'b1, 1'b1, 32'h0, "R9 "},
        '{3'd3, 1'b0, 5'd12, 5'd8, 9'h088, 1'b1, 1'b0, 32'h0, "R8 "},
        '{3'd3, 1'b0, 5'd10, 5'd14, 9'h0C0, 1'b1, 1'b0, 32'h0, "R8 "},
        '{3'd3, 1'b0, 5'd13, 5'd8, 9'h000, 1'b1, 1'b1, 32'h0, "R9 "},
        '{3'd0, 1'b1, 5'd10, 5'd2, 9'h1F8, 1'b0, 1'b0, 32'h0, "R10"},
        '{3'd3, 1'b1, 5'd12, 5'd8, 9'h088, 1'b0, 1'b0, 32'h0, "R10"},
        '{3'd5, 1'b0, 5'd0,  5'd0, 9'h000, 1'b0, 1'b0, 32'h0000_0505, "R11"},
        '{3'd5, 1'b0, 5'd0,  5'd0, 9'h000, 1'b0, 1'b0, 32'h0000_4398, "R11"},
        '{3'd5, 1'b0, 5'd0,  5'd0, 9'h000, 1'b0, 1'b0, 32'h0000_2082, "R11"},
        '{3'd4, 1'b0, 5'd0,  5'd0, 9'h000, 1'b1, 1'b0, 32'h0101_3503, "R12"},
        '{3'd4, 1'b1, 5'd0,  5'd0, 9'h000, 1'b1, 1'b0, 32'h00C4_3023, "R12"},
        '{3'd4, 1'b0, 5'd0,  5'd0, 9'h000, 1'b1, 1'b1, 32'h0101_3583, "R13"},
        '{3'd4, 1'b1, 5'd0,  5'd0, 9'h000, 1'b1, 1'b1, 32'h00D4_3023, "R13"},
        '{3'd4, 1'b0, 5'd0,  5'd0, 9'h000, 1'b0, 1'b0, 32'h0001_2503, "R13"}
    };

    function automatic logic [31:0] enc_in(input vec_t v);
        logic [2:0] d3, b3;
        d3 = v.dreg[2:0];
        b3 = v.breg[2:0];
        case (v.kind)
            3'd0: return {16'h0, 3'b011, v.off[5], v.dreg, v.off[4:3], v.off[8:6], 2'b10};
            3'd1: return {16'h0, 3'b111, v.off[5:3], v.off[8:6], v.dreg, 2'b10};
            3'd2: return {16'h0, 3'b011, v.off[5:3], b3, v.off[7:6], d3, 2'b00};
            3'd3: return {16'h0, 3'b111, v.off[5:3], b3, v.off[7:6], d3, 2'b00};
            default: return v.raw;
        endcase
    endfunction

    function automatic logic [31:0] exp_out(input vec_t v);
        logic [11:0] imm;
        imm = {3'b000, v.off};
        if (!v.vld || v.ill) return 32'h0;
        case (v.kind)
            3'd0, 3'd2: return {imm, v.breg, 3'b011, v.dreg, 7'b0000011};
            3'd1, 3'd3: return {imm[11:5], v.dreg, v.breg, 3'b011, imm[4:0], 7'b0100011};
            default:    return v.raw;
        endcase
    endfunction

    task automatic check(input string req, input logic ev, input logic ei, input logic [31:0] ew);
        n_chk++;
        if (out_vld !== ev || out_illegal !== ei || out_word !== ew) begin
            n_err++;
            $display("FAIL %s: got vld=%b ill=%b word=%h, expected vld=%b ill=%b word=%h",
                     req, out_vld, out_illegal, out_word, ev, ei, ew);
        end
    endtask

    task automatic apply(input logic v, input logic fp, input logic [31:0] w);
        in_vld   = v;
        fp_cmode = fp;
        in_word  = w;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R2: watchdog expired, got no finish, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with a legal word present
        @(negedge clk);
        apply(1'b1, 1'b0, enc_in(TBL[0]));
        check("R1", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, TBL[i].fp, enc_in(TBL[i]));
            check($sformatf("%s vec%0d", TBL[i].tag, i), TBL[i].vld, TBL[i].ill, exp_out(TBL[i]));
        end

        // R2: result held until the next edge, then replaced
        apply(1'b1, 1'b0, enc_in(TBL[7]));
        in_word = enc_in(TBL[10]);
        #1;
        check("R2 hold", 1'b1, 1'b0, exp_out(TBL[7]));
        @(posedge clk);
        @(negedge clk);
        check("R2 next", 1'b1, 1'b0, exp_out(TBL[10]));

        // R2: idle input clears all outputs
        apply(1'b0, 1'b0, enc_in(TBL[10]));
        check("R2 idle", 1'b0, 1'b0, 32'h0);

        // R4 then R3 back to back: reserved flag must not linger
        apply(1'b1, 1'b0, enc_in(TBL[2]));
        check("R4 x0", 1'b1, 1'b1, 32'h0);
        apply(1'b1, 1'b0, enc_in(TBL[1]));
        check("R3 after R4", 1'b1, 1'b0, exp_out(TBL[1]));

        // R10: mode high, then low again restores recognition of the same word
        apply(1'b1, 1'b1, enc_in(TBL[5]));
        check("R10 on", 1'b0, 1'b0, 32'h0);
        apply(1'b1, 1'b0, enc_in(TBL[5]));
        check("R5 mode off", 1'b1, 1'b0, exp_out(TBL[5]));

        // R12: wide word with mode high passes unchanged
        apply(1'b1, 1'b1, 32'h0101_3503);
        check("R12 mode on", 1'b1, 1'b0, 32'h0101_3503);

        // R1: reset mid-stream clears outputs
        rst_n = 1'b0;
        #1;
        check("R1 async", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule